// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block sits between a set of configuration inputs and an external analog converter core. It decides which channel to convert next, issues a one-cycle start strobe with the channel index and waits for the converter's done flag. It then reports the 10-bit result together with the channel it came from, and waits a programmable number of idle cycles before the next conversion. The block also generates a divided clock for the converter while a run is active.

There are two channel policies. In fixed mode a single selected channel is converted over and over. In scan mode the channels whose enable bits are set are visited in rising index order, wrapping from the highest enabled channel back to the lowest. There are also two pacing policies. In continuous mode conversions follow each other automatically. In single mode each conversion waits for a trigger strobe. All configuration is captured when the run enable rises, so software must drop and raise the run enable for a new setting to take effect.

Top module: `adc_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, conv_start, res_valid and conv_clk are all 0.
- R2: A run begins only on a cycle where cfg_run rises (was 0, is now 1) while cfg_pwrdn is 0. A rise of cfg_run while cfg_pwrdn is 1 starts nothing, and a later clearing of cfg_pwrdn alone does not start a run either. When cfg_run is 0 or cfg_pwrdn is 1, conv_start is 0 in that cycle, and conv_clk is 0 from the next cycle on.
- R3: cfg_single, cfg_fixed, cfg_fix_ch, cfg_ch_en, cfg_gap and cfg_div are sampled only on the cycle a run begins. Changing them during a run has no effect until the run is stopped and begun again.
- R4: With cfg_fixed = 1, every conversion drives conv_sel equal to the captured cfg_fix_ch, a binary channel index.
- R5: With cfg_fixed = 0 (scan), only channels whose bit in cfg_ch_en is 1 are converted (bit i is channel i). The first conversion uses the lowest enabled channel, and each following one uses the next higher enabled channel, wrapping to the lowest. With cfg_ch_en all zero, no start is ever issued.
- R6: With cfg_single = 1, a conversion starts only in a cycle where single_trig is 1 while the sequencer is ready: running, not converting and past its idle interval. A trigger at any other time is dropped and does not start a later conversion.
- R7: With cfg_single = 0, conversions restart on their own for as long as the run lasts.
- R8: After the cycle in which conv_done is accepted, exactly cfg_gap idle cycles pass before the next conv_start can be issued. With a gap of 0, the next start may come in the very next cycle.
- R9: conv_done is accepted only while a conversion is in progress. The cycle after an accepted done, res_valid is 1 for one cycle, with res_data equal to conv_data and res_ch equal to the converted channel. A done at any other time produces no result.
- R10: During a run, conv_clk toggles every max(d/2, 1) cycles, where d is the captured divider, starting low from the cycle a run begins. An odd cfg_div at the start of a run is rejected and the last accepted even value is kept. The value after reset is 0.
- R11: conv_start is high for exactly one cycle per conversion, and conv_sel holds its value from the start strobe until the accepted done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_run | input | 1 | Run enable; a rising edge begins a run |
| cfg_pwrdn | input | 1 | Power-down; 1 stops and blocks conversions |
| cfg_single | input | 1 | 1 = triggered single conversions, 0 = continuous |
| cfg_fixed | input | 1 | 1 = fixed channel, 0 = scan over enable mask |
| cfg_fix_ch | input | 3 | Channel used in fixed mode |
| cfg_ch_en | input | 8 | Per-channel enable mask for scan mode |
| cfg_div | input | 4 | Converter clock divider, even values only |
| cfg_gap | input | 16 | Idle cycles between conversions |
| single_trig | input | 1 | One-cycle trigger strobe for single mode |
| conv_clk | output | 1 | Divided clock to the converter core |
| conv_sel | output | 3 | Channel index for the converter |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_done | input | 1 | Converter completion flag |
| conv_data | input | 10 | Converter result, valid with conv_done |
| res_valid | output | 1 | Result valid strobe |
| res_data | output | 10 | Reported result |
| res_ch | output | 3 | Channel of the reported result |

## Verification
A corrupted channel pointer shows up on conv_sel at the very next start strobe, and on res_ch one cycle after that conversion's done. A wrong phase or interval count moves conv_start off its predicted cycle, which the bench detects within one conversion period. Wrongly captured configuration appears as the wrong channel sequence or the wrong conv_clk period within a few cycles of a run beginning. The bench predicts every output cycle by cycle and compares them, so the first divergent cycle is reported.

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq #(
  parameter int NCH = 8,
  parameter int RW  = 10,
  parameter int GW  = 16,
  parameter int DW  = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_run,
  input  logic          cfg_pwrdn,
  input  logic          cfg_single,
  input  logic          cfg_fixed,
  input  logic [CW-1:0] cfg_fix_ch,
  input  logic [NCH-1:0] cfg_ch_en,
  input  logic [DW-1:0] cfg_div,
  input  logic [GW-1:0] cfg_gap,
  input  logic          single_trig,
  output logic          conv_clk,
  output logic [CW-1:0] conv_sel,
  output logic          conv_start,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_data,
  output logic          res_valid,
  output logic [RW-1:0] res_data,
  output logic [CW-1:0] res_ch
);
  typedef enum logic [1:0] {ST_RDY, ST_GAP, ST_BUSY} st_t;
  localparam logic [DW-2:0] ONE = 1;

  st_t            st;
  logic           act, run_q, single_q, fixed_q;
  logic [CW-1:0]  fch_q;
  logic [NCH-1:0] en_q;
  logic [GW-1:0]  gap_q, gcnt;
  logic [DW-1:0]  div_q;
  logic [DW-2:0]  dcnt;

  function automatic logic [CW-1:0] pick(input logic [NCH-1:0] m, input logic [CW-1:0] from);
    pick = from;
    for (int i = NCH; i >= 1; i--)
      if (m[(int'(from) + i) % NCH]) pick = CW'((int'(from) + i) % NCH);
  endfunction

  wire go     = cfg_run & ~cfg_pwrdn;
  wire launch = go & ~run_q;
  wire elig   = fixed_q | (|en_q);
  wire [CW-1:0] first = cfg_fixed ? cfg_fix_ch : pick(cfg_ch_en, CW'(NCH - 1));
  wire [CW-1:0] nxt   = fixed_q ? fch_q : pick(en_q, conv_sel);
  wire [DW-2:0] lim   = (div_q[DW-1:1] == '0) ? ONE : div_q[DW-1:1];

  assign conv_start = go & act & (st == ST_RDY) & elig & (~single_q | single_trig);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_RDY; act <= 1'b0; run_q <= 1'b0;
      single_q <= 1'b0; fixed_q <= 1'b0; fch_q <= '0; en_q <= '0;
      gap_q <= '0; gcnt <= '0; div_q <= '0; conv_sel <= '0;
      res_valid <= 1'b0; res_data <= '0; res_ch <= '0;
    end else begin
      run_q <= cfg_run;
      res_valid <= 1'b0;
      if (!go) act <= 1'b0;
      else if (launch) begin
        act <= 1'b1; st <= ST_RDY;
        single_q <= cfg_single; fixed_q <= cfg_fixed; fch_q <= cfg_fix_ch;
        en_q <= cfg_ch_en; gap_q <= cfg_gap; conv_sel <= first;
        if (!cfg_div[0]) div_q <= cfg_div;
      end else if (act) begin
        case (st)
          ST_RDY:  if (conv_start) st <= ST_BUSY;
          ST_BUSY: if (conv_done) begin
            res_valid <= 1'b1; res_data <= conv_data; res_ch <= conv_sel;
            conv_sel <= nxt;
            if (gap_q == '0) st <= ST_RDY;
            else begin st <= ST_GAP; gcnt <= gap_q; end
          end
          ST_GAP: if (gcnt == GW'(1)) st <= ST_RDY; else gcnt <= gcnt - GW'(1);
          default: st <= ST_RDY;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !(go && act)) begin
      dcnt <= '0; conv_clk <= 1'b0;
    end else if (dcnt == lim - ONE) begin
      dcnt <= '0; conv_clk <= ~conv_clk;
    end else dcnt <= dcnt + ONE;
  end

  p_start_onecycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_sel_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (act && st == ST_BUSY && !conv_done && go) |=> $stable(conv_sel));
  p_res_follows_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(conv_done));
  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_run |=> (!conv_clk && !conv_start));
  p_scan_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !fixed_q) |-> en_q[conv_sel]);
  p_fixed_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && fixed_q) |-> (conv_sel == fch_q));
endmodule

// File: tb/sim_adc_seq.sv
`timescale 1ns/1ps
module sim_adc_seq;
  localparam int LAT = 3;
  logic clk = 0, rst_n = 0;
  logic cfg_run = 0, cfg_pwrdn = 0, cfg_single = 0, cfg_fixed = 0;
  logic [2:0] cfg_fix_ch = 0;
  logic [7:0] cfg_ch_en = 0;
  logic [3:0] cfg_div = 0;
  logic [15:0] cfg_gap = 0;
  logic single_trig = 0, spur = 0;
  logic conv_clk, conv_start, res_valid;
  logic [2:0] conv_sel, res_ch;
  logic [9:0] res_data;
  logic cv_done_r = 0;
  logic [9:0] cv_data_r = 0;
  wire conv_done = cv_done_r | spur;
  wire [9:0] conv_data = spur ? 10'h2AA : cv_data_r;

  adc_seq u0 (.clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_pwrdn(cfg_pwrdn),
    .cfg_single(cfg_single), .cfg_fixed(cfg_fixed), .cfg_fix_ch(cfg_fix_ch),
    .cfg_ch_en(cfg_ch_en), .cfg_div(cfg_div), .cfg_gap(cfg_gap), .single_trig(single_trig),
    .conv_clk(conv_clk), .conv_sel(conv_sel), .conv_start(conv_start),
    .conv_done(conv_done), .conv_data(conv_data), .res_valid(res_valid),
    .res_data(res_data), .res_ch(res_ch));

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit finished = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model state
  bit m_act = 0, m_runq = 0, m_clk = 0, s_single = 0, s_fixed = 0;
  int m_ph = 0, m_ch = 0, m_gapc = 0, m_dcnt = 0, s_fch = 0, s_gap = 0, s_div = 0;
  bit [7:0] s_mask = 0;
  bit e_rv = 0;
  int e_rd = 0, e_rc = 0, cv_lat = 0, cv_ch = 0, cv_k = 0;

  function automatic int m_next(input bit [7:0] mask, input int c);
    int q[$];
    for (int i = 0; i < 8; i++) if (mask[i]) q.push_back(i);
    if (q.size() == 0) return c;
    foreach (q[j]) if (q[j] > c) return q[j];
    return q[0];
  endfunction

  function automatic bit exp_start();
    return cfg_run && !cfg_pwrdn && m_act && m_ph == 0 &&
           (s_fixed || s_mask != 0) && (!s_single || single_trig);
  endfunction

  always @(posedge clk) begin
    bit st, go;
    int sel_now, lim;
    cyc++;
    if (!rst_n) begin
      m_act = 0; m_runq = 0; m_clk = 0; m_dcnt = 0; s_div = 0; e_rv = 0;
      m_ph = 0; m_ch = 0; s_fixed = 0; s_mask = 0; s_single = 0; cv_lat = 0;
    end else begin
      st = exp_start(); go = cfg_run && !cfg_pwrdn; sel_now = m_ch;
      if (go && m_act) begin
        lim = (s_div / 2 == 0) ? 1 : s_div / 2;
        if (m_dcnt == lim - 1) begin m_dcnt = 0; m_clk = !m_clk; end
        else m_dcnt++;
      end else begin m_dcnt = 0; m_clk = 0; end
      e_rv = 0;
      if (!go) m_act = 0;
      else if (!m_runq) begin
        m_act = 1; m_ph = 0; s_single = cfg_single; s_fixed = cfg_fixed;
        s_fch = cfg_fix_ch; s_mask = cfg_ch_en; s_gap = cfg_gap;
        if (cfg_div % 2 == 0) s_div = cfg_div;
        m_ch = s_fixed ? s_fch : m_next(s_mask, -1);
      end else if (m_act) begin
        if (m_ph == 0 && st) m_ph = 2;
        else if (m_ph == 2 && conv_done) begin
          e_rv = 1; e_rd = conv_data; e_rc = m_ch;
          m_ch = s_fixed ? s_fch : m_next(s_mask, m_ch);
          if (s_gap == 0) m_ph = 0; else begin m_ph = 1; m_gapc = s_gap; end
        end else if (m_ph == 1) begin
          m_gapc--;
          if (m_gapc == 0) m_ph = 0;
        end
      end
      m_runq = cfg_run;
      if (cv_lat > 0) cv_lat--;
      if (st) begin cv_lat = LAT; cv_ch = sel_now; cv_k++; end
    end
  end

  always @(negedge clk) begin
    cv_done_r = (cv_lat == 1);
    cv_data_r = 10'((cv_ch * 61 + cv_k * 37 + 5) % 1024);
  end

  int lg_ch[$], lg_cyc[$];
  int n_res = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk(conv_start == exp_start(), "R11 start", conv_start, exp_start());
      if (m_act && (m_ph == 2 || exp_start()))
        chk(conv_sel == 3'(m_ch), s_fixed ? "R4 sel" : "R5 sel", conv_sel, m_ch);
      chk(conv_clk == m_clk, "R10 conv_clk", conv_clk, m_clk);
      chk(res_valid == e_rv, "R9 res_valid", res_valid, e_rv);
      if (e_rv) begin
        chk(res_data == 10'(e_rd), "R9 res_data", res_data, e_rd);
        chk(res_ch == 3'(e_rc), "R9 res_ch", res_ch, e_rc);
      end
      if (conv_start) begin lg_ch.push_back(conv_sel); lg_cyc.push_back(cyc); end
      if (res_valid) n_res++;
    end
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic clr(); lg_ch.delete(); lg_cyc.delete(); n_res = 0; endtask
  task automatic stop_run(); cfg_run = 0; wt(3); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1; n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int hi, any_bad, varied;
    wt(4);
    chk(conv_start == 0, "R1 start", conv_start, 0);
    chk(res_valid == 0, "R1 res_valid", res_valid, 0);
    chk(conv_clk == 0, "R1 conv_clk", conv_clk, 0);
    rst_n = 1;
    wt(1);
    chk(conv_start == 0 && conv_clk == 0, "R1 after", conv_clk, 0);

    // fixed continuous
    cfg_fixed = 1; cfg_fix_ch = 6; cfg_gap = 2; cfg_div = 4; clr(); cfg_run = 1;
    wt(40);
    chk(lg_ch.size() >= 5, "R7 repeats", lg_ch.size(), 5);
    any_bad = 0; foreach (lg_ch[i]) if (lg_ch[i] != 6) any_bad++;
    chk(any_bad == 0, "R4 fixed channel", any_bad, 0);
    chk(lg_cyc[2] - lg_cyc[1] == 2 + LAT + 1, "R8 gap 2", lg_cyc[2] - lg_cyc[1], 2 + LAT + 1);
    stop_run();

    // scan, gap 0
    cfg_fixed = 0; cfg_ch_en = 8'hA4; cfg_gap = 0; cfg_div = 6; clr(); cfg_run = 1;
    wt(30);
    chk(lg_ch.size() >= 5, "R5 count", lg_ch.size(), 5);
    chk(lg_ch[0] == 2 && lg_ch[1] == 5 && lg_ch[2] == 7 && lg_ch[3] == 2 && lg_ch[4] == 5,
        "R5 order", lg_ch[3], 2);
    chk(lg_cyc[1] - lg_cyc[0] == LAT + 1, "R8 gap 0", lg_cyc[1] - lg_cyc[0], LAT + 1);
    cfg_ch_en = 8'hFF; cfg_fixed = 1; cfg_fix_ch = 1; cfg_div = 2; clr();
    wt(30);
    any_bad = 0; varied = 0;
    foreach (lg_ch[i]) begin
      if (lg_ch[i] != 2 && lg_ch[i] != 5 && lg_ch[i] != 7) any_bad++;
      if (lg_ch[i] != lg_ch[0]) varied = 1;
    end
    chk(any_bad == 0 && varied == 1, "R3 held during run", any_bad, 0);
    stop_run(); clr(); cfg_run = 1;
    wt(20);
    any_bad = 0; foreach (lg_ch[i]) if (lg_ch[i] != 1) any_bad++;
    chk(lg_ch.size() > 0 && any_bad == 0, "R3 taken on restart", any_bad, 0);
    stop_run();

    // divider: odd rejected
    cfg_div = 6; cfg_run = 1; wt(10); stop_run();
    cfg_div = 5; cfg_run = 1; wt(3);
    while (conv_clk != 0) @(negedge clk);
    while (conv_clk != 1) @(negedge clk);
    hi = 0; while (conv_clk == 1) begin hi++; @(negedge clk); end
    chk(hi == 3, "R10 odd divider kept", hi, 3);
    stop_run();

    // empty scan mask
    cfg_fixed = 0; cfg_ch_en = 0; clr(); cfg_run = 1; wt(20);
    chk(lg_ch.size() == 0, "R5 empty mask", lg_ch.size(), 0);
    stop_run();

    // power-down
    cfg_ch_en = 8'h0F; cfg_pwrdn = 1; clr(); cfg_run = 1; wt(15);
    chk(lg_ch.size() == 0, "R2 powered down", lg_ch.size(), 0);
    cfg_pwrdn = 0; wt(15);
    chk(lg_ch.size() == 0, "R2 needs new rise", lg_ch.size(), 0);
    stop_run(); cfg_run = 1; wt(15);
    chk(lg_ch.size() > 0, "R2 run begins", lg_ch.size(), 1);
    cfg_pwrdn = 1; wt(1); clr(); wt(15);
    chk(lg_ch.size() == 0 && conv_clk == 0, "R2 stop on pwrdn", lg_ch.size(), 0);
    stop_run(); cfg_pwrdn = 0;

    // single mode
    cfg_single = 1; cfg_fixed = 1; cfg_fix_ch = 3; cfg_gap = 1; clr(); cfg_run = 1;
    wt(15);
    chk(lg_ch.size() == 0, "R6 waits for trigger", lg_ch.size(), 0);
    spur = 1; wt(1); spur = 0; wt(1);
    chk(res_valid == 0 && n_res == 0, "R9 stray done", n_res, 0);
    single_trig = 1; wt(2); single_trig = 0;
    wt(12);
    chk(lg_ch.size() == 1 && lg_ch[0] == 3, "R6 one start", lg_ch.size(), 1);
    chk(n_res == 1, "R9 one result", n_res, 1);
    single_trig = 1; wt(1); single_trig = 0; wt(10);
    chk(lg_ch.size() == 2, "R6 second trigger", lg_ch.size(), 2);
    stop_run();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule